// File: doc/BRIEF.md
# Narrow-Value Fast Parity Generator

This block produces the even parity bit of a 64-bit word on its way into parity-protected storage, such as a register file or an issue-queue operand field. Many such words are small integers: once the low byte is sign-extended, they are fully described. For these narrow words the block takes its parity from the low byte alone and delivers it one clock after acceptance. Every other word goes through a full XOR reduction that is split over two register stages, so its result appears two clocks after acceptance.

A word can be accepted on every cycle. Results always leave in the order in which their words arrived. When the two-stage path still holds an earlier word, a narrow word that follows is sent down the two-stage path as well, so that it cannot overtake that earlier word. Each result carries a flag that shows whether it came out with the one-cycle latency.

Top module: `fast_parity_gen`

## Requirements
- R1: For every accepted word, `out_parity` equals the XOR of all 64 bits of `in_data`, whichever path produced it.
- R2: A word is narrow when bits 63 down to 7 all hold the same value (all zeros or all ones). Any other word is wide. For example, 0x80, 0x100 and 0xFFFF_FFFF_FFFF_FF7F are wide.
- R3: A narrow word that is accepted while the two-stage path is empty produces `out_valid`=1 and `out_fast`=1 on the clock edge after the edge that accepted it.
- R4: A wide word produces `out_valid`=1 and `out_fast`=0 two clock edges after the edge that accepted it.
- R5: A narrow word accepted in the cycle just after a word that entered the two-stage path also takes two cycles and has `out_fast`=0. Results leave in input order.
- R6: `out_valid` is high for exactly one cycle for each accepted word, and is low in every other cycle.
- R7: While `rst` is high at a clock edge, the outputs and the two-stage path are cleared on that edge, and words that were in flight are dropped.
- R8: While `out_valid` is low, `out_parity` and `out_fast` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_data` is presented this cycle |
| in_data | input | 64 | Word to protect |
| out_valid | output | 1 | A parity result is present |
| out_parity | output | 1 | Even parity of the matching input word |
| out_fast | output | 1 | The result arrived one cycle after its word was accepted |

## Verification
The hardest case to reach from the ports is the ordering hazard: a narrow word that arrives while a wide word is still in the second XOR stage. Another case is a run of narrow words that stays on the two-stage path behind such a word until there is a gap. The stimulus table places narrow words directly behind wide ones, first singly and then as a run, and ends the run with an idle slot so that the return to one-cycle latency is also seen. Boundary words that differ from a narrow pattern only at bit 7 or bit 8 exercise the narrow test itself.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  typedef enum logic {
    PATH_SLOW = 1'b0,
    PATH_FAST = 1'b1
  } path_e;

  typedef struct packed {
    logic  valid;
    logic  parity;
    path_e path;
  } result_t;

  localparam result_t RESULT_IDLE = '{valid: 1'b0, parity: 1'b0, path: PATH_SLOW};

endpackage

// File: rtl/fpg_narrow_detect.sv
module fpg_narrow_detect #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] word,
  output logic              is_narrow
);
  // The sign bit of the low slice plus every bit above it must agree.
  localparam int TOP_W = DATA_W - NARROW_W + 1;

  logic [TOP_W-1:0] top_bits;

  assign top_bits  = word[DATA_W-1:NARROW_W-1];
  assign is_narrow = (&top_bits) | ~(|top_bits);
endmodule

// File: rtl/fpg_xor_fold.sv
module fpg_xor_fold #(
  parameter int DATA_W = 64,
  parameter int GROUPS = 8
) (
  input  logic [DATA_W-1:0] word,
  output logic [GROUPS-1:0] part
);
  localparam int GROUP_W = DATA_W / GROUPS;

  for (genvar g = 0; g < GROUPS; g++) begin : g_fold
    assign part[g] = ^word[g*GROUP_W +: GROUP_W];
  end
endmodule

// File: rtl/fast_parity_gen.sv
module fast_parity_gen #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8,
  parameter int GROUPS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_parity,
  output logic              out_fast
);
  import fpg_pkg::*;

  logic              word_narrow;
  logic [GROUPS-1:0] fold_now;
  logic              low_parity;

  // Second stage of the long path: one partial XOR per group.
  logic              slow_v;
  logic [GROUPS-1:0] slow_part;

  logic    take_slow;
  logic    take_fast;
  result_t next_res;
  result_t res_q;

  fpg_narrow_detect #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W)
  ) u_detect (
    .word     (in_data),
    .is_narrow(word_narrow)
  );

  fpg_xor_fold #(
    .DATA_W(DATA_W),
    .GROUPS(GROUPS)
  ) u_fold (
    .word(in_data),
    .part(fold_now)
  );

  assign low_parity = ^in_data[NARROW_W-1:0];

  // A pending long-path word forces followers onto the long path too,
  // so that nothing overtakes it.
  assign take_slow = in_valid & (~word_narrow | slow_v);
  assign take_fast = in_valid & word_narrow & ~slow_v;

  always_comb begin
    next_res = RESULT_IDLE;
    if (slow_v) begin
      next_res.valid  = 1'b1;
      next_res.parity = ^slow_part;
      next_res.path   = PATH_SLOW;
    end else if (take_fast) begin
      next_res.valid  = 1'b1;
      next_res.parity = low_parity;
      next_res.path   = PATH_FAST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_v    <= 1'b0;
      slow_part <= '0;
      res_q     <= RESULT_IDLE;
    end else begin
      slow_v    <= take_slow;
      slow_part <= take_slow ? fold_now : '0;
      res_q     <= next_res;
    end
  end

  assign out_valid  = res_q.valid;
  assign out_parity = res_q.parity;
  assign out_fast   = (res_q.path == PATH_FAST);
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_parity,
  input logic              out_fast,
  input logic              slow_busy
);
  logic narrow_in;
  assign narrow_in = (in_data[DATA_W-1:NARROW_W-1] == '0) ||
                     (in_data[DATA_W-1:NARROW_W-1] == '1);

  // R3
  a_r3_fast_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow_in && !slow_busy) |=>
      (out_valid && out_fast && out_parity == $past(^in_data)));

  // R4 and R1 on the long path
  a_r4_wide_two_cycles: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !narrow_in) |=> ##1
      (out_valid && !out_fast && out_parity == $past(^in_data, 2)));

  // R5
  a_r5_no_overtake: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slow_busy) |=> ##1
      (out_valid && !out_fast && out_parity == $past(^in_data, 2)));

  // R6
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!in_valid ##1 !in_valid) |=> !out_valid);

  // R7
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !slow_busy));

  // R8
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_parity && !out_fast));
endmodule

bind fast_parity_gen fpg_checker #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W)
) u_fpg_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_parity(out_parity),
  .out_fast  (out_fast),
  .slow_busy (slow_v)
);

// File: tb/fast_parity_gen_test.sv
`timescale 1ns/1ps
module fast_parity_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid, out_parity, out_fast;

  int n_run  = 0;
  int n_fail = 0;

  // Expected state derived from R3 to R8
  logic e_slow_v = 1'b0, e_slow_p = 1'b0;
  logic e_v = 1'b0, e_p = 1'b0, e_f = 1'b0;

  always #2.5 clk = ~clk;

  fast_parity_gen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_parity(out_parity), .out_fast(out_fast)
  );

  // {valid, word}
  localparam logic [64:0] VEC [18] = '{
    {1'b1, 64'h0000_0000_0000_0000},  // narrow zero (R2)
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF},  // narrow all ones (R2)
    {1'b1, 64'hFFFF_FFFF_FFFF_FF80},  // -128, narrow
    {1'b1, 64'h0000_0000_0000_007F},  // 127, narrow
    {1'b0, 64'h0},
    {1'b1, 64'h0000_0000_0000_0080},  // wide at bit 7 (R2)
    {1'b0, 64'h0},
    {1'b1, 64'h0000_0000_0000_0100},  // wide at bit 8 (R2)
    {1'b1, 64'h0000_0000_0000_007F},  // narrow behind wide (R5)
    {1'b1, 64'h0000_0000_0000_0003},  // narrow run stays slow (R5)
    {1'b0, 64'h0},
    {1'b0, 64'h0},
    {1'b1, 64'hFFFF_FFFF_FFFF_FE80},  // wide, bit 8 clear (R2)
    {1'b1, 64'hFFFF_FFFF_FFFF_FF7F},  // wide, bit 7 clear
    {1'b1, 64'h1234_5678_9ABC_DEF0},  // wide
    {1'b0, 64'h0},
    {1'b1, 64'h0000_0000_0000_0055},  // narrow after gap (R3)
    {1'b0, 64'h0}
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [63:0] d);
    logic nar, n_sv, n_sp, n_v, n_p, n_f;
    @(negedge clk);
    check("R6", out_valid, e_v, "out_valid");
    if (e_v) begin
      check("R1", out_parity, e_p, "out_parity");
      check(e_f ? "R3" : "R4", out_fast, e_f, "out_fast");
    end else begin
      check("R8", out_parity, 1'b0, "idle out_parity");
      check("R8", out_fast, 1'b0, "idle out_fast");
    end
    rst = r; in_valid = v; in_data = d;
    nar  = (&d[63:7]) | ~(|d[63:7]);
    n_sv = v & (~nar | e_slow_v);
    n_sp = ^d;
    n_v  = e_slow_v | (v & nar);
    n_f  = ~e_slow_v & v & nar;
    n_p  = e_slow_v ? e_slow_p : (n_f ? ^d : 1'b0);
    if (r) begin
      n_sv = 0; n_sp = 0; n_v = 0; n_p = 0; n_f = 0;
    end
    e_slow_v = n_sv; e_slow_p = n_sv ? n_sp : 1'b0;
    e_v = n_v; e_p = n_p; e_f = n_f;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    // R7: outputs cleared after reset
    @(negedge clk);
    check("R7", out_valid, 1'b0, "reset out_valid");
    check("R7", out_fast, 1'b0, "reset out_fast");
    for (int i = 0; i < 18; i++) step(1'b0, VEC[i][64], VEC[i][63:0]);
    // R7: a wide word in flight is dropped by reset
    step(1'b0, 1'b1, 64'h0F00_0000_0000_0001);
    step(1'b1, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    // R5 then R3: wide, narrow, gap, narrow
    step(1'b0, 1'b1, 64'h8000_0000_0000_0000);
    step(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b1, 64'h0000_0000_0000_0001);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule